// File: doc/BRIEF.md
# Memory-Mapped Asynchronous Serial Port

This block is an asynchronous serial transmitter and receiver that a processor sees as three byte-wide registers on a simple select/write bus. The control register turns the transmit and receive paths on and off and selects which conditions may raise the interrupt line. The status register exposes the flags that software polls. The data register is shared: writing it loads the transmit buffer, and reading it takes the received byte.

Characters use 8N1 framing. Every bit lasts 16 pulses of an external bit-rate enable. The receiver synchronises the line and takes three votes around the middle of each bit. It raises an error flag when the three votes disagree, when the stop bit is low, or when a new character completes while the previous one is still unread. Software can use the port by polling the status flags, or it can enable the interrupt sources and react to the single interrupt output.

Top module: `sio_port`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the status register (address 1) reads 0xC0, `txd` is 1 and `irq` is 0.
- R2: A write to address 0 stores all eight control bits, and a read returns them unchanged. The bit layout from bit 7 down to bit 0 is: transmit-empty interrupt enable, transmit-done interrupt enable, receive interrupt enable, idle interrupt enable, transmit on (0x08), receive on (0x04), a stored wake bit with no function, and line break (0x01).
- R3: A transmitted character is a low start bit, then the 8 data bits least significant first, then a high stop bit. Each bit lasts 16 `tick` pulses. Characters are sent in the order they were written, with no gap when the buffer is refilled in time.
- R4: Status bit 7 (0x80, transmit empty) clears on a write to the data register (address 2) and sets again when the byte moves into the shifter. Status bit 6 (0x40, transmit done) is 0 while a byte is pending or being shifted, and 1 otherwise.
- R5: While transmit on is 0, no new character starts and a written byte stays in the buffer. Clearing transmit on while a character is being shifted lets that character finish.
- R6: While the line break bit is 1, `txd` is driven low.
- R7: A completed character sets status bit 5 (0x20, receive full). A read of the data register returns the byte and clears receive full, idle and all three error flags.
- R8: If a character completes while receive full is set, status bit 3 (0x08, overrun) sets, and the unread byte is kept.
- R9: A low stop bit sets status bit 1 (0x02, framing). The byte is still delivered.
- R10: If the three mid-bit votes of any bit in a character disagree, status bit 2 (0x04, noise) sets, and the majority value is used for the data.
- R11: Status bit 4 (0x10, idle) sets after the line has stayed high for 10 bit times following a received character. It sets only once per character.
- R12: While receive on is 0, the receiver ignores the line. Clearing receive on abandons a character in progress, and that character never sets receive full.
- R13: `irq` is 1 exactly when one of these holds: transmit empty and its enable are both 1; transmit done and its enable are both 1; idle and its enable are both 1; or the receive interrupt enable is 1 and receive full or any error flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Bit-rate enable, 16 pulses per bit |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench disables the transmitter while a byte is buffered and again while a character is mid-shift. A design that gates the shifter instead of the start of a character would either lose the buffered byte or truncate the frame, and the scoreboard would then see a missing, extra or corrupt character. Two characters arrive without a read in between; a design that lets the newer byte overwrite the older one returns the wrong data and shows no overrun. A single-tick glitch is placed on one data bit, so a design that samples only once either flips that bit or never reports noise. The idle flag is checked both before and after ten bit times of quiet line, which catches a counter that is too short or one that keeps re-arming.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  // control bit positions (fixed: software masks depend on them)
  localparam int CB_TXE_IE  = 7;
  localparam int CB_TXC_IE  = 6;
  localparam int CB_RX_IE   = 5;
  localparam int CB_IDLE_IE = 4;
  localparam int CB_TX_ON   = 3;
  localparam int CB_RX_ON   = 2;
  localparam int CB_WAKE    = 1;
  localparam int CB_BRK     = 0;

  // ordered to match status bits 7..1
  typedef struct packed {
    logic txe;
    logic txc;
    logic rxf;
    logic idle;
    logic ovr;
    logic noise;
    logic frm;
  } flags_t;

  function automatic logic [7:0] pack_status(flags_t f);
    return {f, 1'b0};
  endfunction

  function automatic logic any_err(flags_t f);
    return f.ovr | f.noise | f.frm;
  endfunction

  function automatic logic irq_combine(logic [7:0] c, flags_t f);
    return (f.txe  & c[CB_TXE_IE])
         | (f.txc  & c[CB_TXC_IE])
         | (f.idle & c[CB_IDLE_IE])
         | (c[CB_RX_IE] & (f.rxf | any_err(f)));
  endfunction

  function automatic logic vote3(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic split3(logic a, logic b, logic c);
    return !((a == b) && (b == c));
  endfunction

endpackage

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] din,
  output logic          busy,
  output logic          ser
);
  localparam int FRAME_BITS = DW + 2;
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] shreg;
  logic [CW-1:0]         cnt;
  logic [BW-1:0]         idx;
  logic                  busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '1;
      cnt    <= '0;
      idx    <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q && start) begin
      busy_q <= 1'b1;
      shreg  <= {1'b1, din, 1'b0};
      cnt    <= '0;
      idx    <= '0;
    end else if (busy_q && tick) begin
      if (cnt == CW'(OSR - 1)) begin
        cnt   <= '0;
        shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
        if (idx == BW'(FRAME_BITS - 1)) busy_q <= 1'b0;
        else                            idx    <= idx + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign ser  = busy_q ? shreg[0] : 1'b1;

  // R3
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start) |=> (busy_q && !ser));

  // R3
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick && !start) |=> $stable(ser));

endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int DW        = 8,
  parameter int IDLE_BITS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          rxd,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          ferr,
  output logic          noise,
  output logic          idle_hit
);
  localparam int FRAME_BITS = DW + 2;
  localparam int CW         = $clog2(OSR);
  localparam int BW         = $clog2(FRAME_BITS);
  localparam int MID        = OSR / 2;
  localparam int IDLE_TICKS = IDLE_BITS * OSR;
  localparam int IW         = $clog2(IDLE_TICKS + 1);

  logic          s1, s2;
  logic          act, armed, noisy;
  logic          smp_a, smp_b;
  logic [CW-1:0] cnt;
  logic [BW-1:0] idx;
  logic [DW-1:0] shd;
  logic [IW-1:0] idle_cnt;
  logic          bitv, bitn;

  assign bitv = vote3(smp_a, smp_b, s2);
  assign bitn = split3(smp_a, smp_b, s2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act      <= 1'b0;
      armed    <= 1'b0;
      noisy    <= 1'b0;
      smp_a    <= 1'b1;
      smp_b    <= 1'b1;
      cnt      <= '0;
      idx      <= '0;
      shd      <= '0;
      idle_cnt <= '0;
      done     <= 1'b0;
      idle_hit <= 1'b0;
      data     <= '0;
      ferr     <= 1'b0;
      noise    <= 1'b0;
    end else begin
      done     <= 1'b0;
      idle_hit <= 1'b0;
      if (!en) begin
        act      <= 1'b0;
        armed    <= 1'b0;
        idle_cnt <= '0;
      end else if (tick) begin
        if (!act) begin
          if (!s2) begin
            act      <= 1'b1;
            cnt      <= CW'(1);
            idx      <= '0;
            idle_cnt <= '0;
          end else if (armed) begin
            if (idle_cnt == IW'(IDLE_TICKS - 1)) begin
              idle_hit <= 1'b1;
              armed    <= 1'b0;
              idle_cnt <= '0;
            end else begin
              idle_cnt <= idle_cnt + 1'b1;
            end
          end
        end else begin
          if (cnt == CW'(OSR - 1)) begin
            cnt <= '0;
            idx <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
          if (cnt == CW'(MID - 1)) smp_a <= s2;
          if (cnt == CW'(MID))     smp_b <= s2;
          if (cnt == CW'(MID + 1)) begin
            if (idx == '0) begin
              noisy <= bitn;
              if (bitv) act <= 1'b0;
            end else if (idx == BW'(FRAME_BITS - 1)) begin
              act   <= 1'b0;
              done  <= 1'b1;
              data  <= shd;
              ferr  <= !bitv;
              noise <= noisy | bitn;
              armed <= 1'b1;
            end else begin
              shd   <= {bitv, shd[DW-1:1]};
              noisy <= noisy | bitn;
            end
          end
        end
      end
    end
  end

  // R12
  rx_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !act);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |-> (!act && !done));

endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       txd,
  input  logic       rxd,
  output logic       irq
);
  localparam int DW = 8;

  logic [7:0]    ctrl;
  logic [DW-1:0] tx_buf, rx_buf;
  logic          txe_q, rxf_q, idle_q, ovr_q, nse_q, frm_q;
  flags_t        flg;

  logic          wr_ctrl, wr_data, rd_data, tx_take;
  logic          tx_busy, tx_ser;
  logic          rx_done, rx_ferr, rx_noise, rx_idle_hit;
  logic [DW-1:0] rx_data;

  assign wr_ctrl = bus_sel &&  bus_wr && (bus_addr == A_CTRL);
  assign wr_data = bus_sel &&  bus_wr && (bus_addr == A_DATA);
  assign rd_data = bus_sel && !bus_wr && (bus_addr == A_DATA);
  assign tx_take = ctrl[CB_TX_ON] && !txe_q && !tx_busy;

  sio_tx #(.OSR(OSR), .DW(DW)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .start (tx_take),
    .din   (tx_buf),
    .busy  (tx_busy),
    .ser   (tx_ser)
  );

  sio_rx #(.OSR(OSR), .DW(DW), .IDLE_BITS(IDLE_BITS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .en       (ctrl[CB_RX_ON]),
    .rxd      (rxd),
    .done     (rx_done),
    .data     (rx_data),
    .ferr     (rx_ferr),
    .noise    (rx_noise),
    .idle_hit (rx_idle_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      tx_buf <= '0;
      txe_q  <= 1'b1;
    end else begin
      if (wr_ctrl) ctrl <= bus_wdata;
      if (tx_take) txe_q <= 1'b1;
      if (wr_data) begin
        tx_buf <= bus_wdata;
        txe_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_buf <= '0;
      rxf_q  <= 1'b0;
      idle_q <= 1'b0;
      ovr_q  <= 1'b0;
      nse_q  <= 1'b0;
      frm_q  <= 1'b0;
    end else begin
      if (rd_data) begin
        rxf_q  <= 1'b0;
        idle_q <= 1'b0;
        ovr_q  <= 1'b0;
        nse_q  <= 1'b0;
        frm_q  <= 1'b0;
      end
      if (rx_done) begin
        if (rxf_q && !rd_data) begin
          ovr_q <= 1'b1;
        end else begin
          rx_buf <= rx_data;
          rxf_q  <= 1'b1;
          frm_q  <= rx_ferr;
          nse_q  <= rx_noise;
        end
      end
      if (rx_idle_hit) idle_q <= 1'b1;
    end
  end

  always_comb begin
    flg.txe   = txe_q;
    flg.txc   = txe_q && !tx_busy;
    flg.rxf   = rxf_q;
    flg.idle  = idle_q;
    flg.ovr   = ovr_q;
    flg.noise = nse_q;
    flg.frm   = frm_q;
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl;
      A_STAT:  bus_rdata = pack_status(flg);
      A_DATA:  bus_rdata = rx_buf;
      default: bus_rdata = '0;
    endcase
  end

  assign txd = ctrl[CB_BRK] ? 1'b0 : tx_ser;
  assign irq = irq_combine(ctrl, flg);

  // R4
  tx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> !txe_q);

  // R5
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[CB_TX_ON] && !tx_busy) |=> !tx_busy);

  // R7
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_done && !rx_idle_hit) |=> (!rxf_q && !ovr_q && !nse_q && !frm_q && !idle_q));

  // R8
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rxf_q && !rd_data) |=> (ovr_q && $stable(rx_buf)));

  // R13
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[7:4] == 4'd0) |-> !irq);

endmodule

// File: tb/sio_port_bench.sv
module sio_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int OSR        = 16;
  localparam int BIT_CLKS   = OSR * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       txd;
  logic       rxd = 1'b1;
  logic       irq;

  int n_tests = 0;
  int n_fail  = 0;
  int frames_seen = 0;
  logic brk_on = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] rd_val;
  logic [7:0] mon_got;
  logic [7:0] mon_exp;
  logic       mon_stop;
  logic       mon_prev = 1'b1;
  logic       rx_bit;
  int         seen0;

  sio_port #(.OSR(OSR), .IDLE_BITS(10)) u_sio_port (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .rxd(rxd), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin : tick_gen
    int tcnt;
    tcnt = 0;
    forever begin
      @(negedge clk);
      tick = (tcnt == TICK_DIV - 1);
      tcnt = (tcnt + 1) % TICK_DIV;
    end
  end

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // driver: records the expected character, then hands it to the port
  task automatic send_tx(input logic [7:0] b);
    logic [7:0] s;
    int guard;
    guard = 0;
    bus_read(2'd1, s);
    while (!s[7] && guard < 4000) begin
      bus_read(2'd1, s);
      guard++;
    end
    check8("R4 empty before write", {7'd0, s[7]}, 8'h01);
    exp_q.push_back(b);
    bus_write(2'd2, b);
  endtask

  task automatic wait_tx_idle();
    logic [7:0] s;
    int guard;
    guard = 0;
    bus_read(2'd1, s);
    while (s != 8'hC0 && guard < 8000) begin
      bus_read(2'd1, s);
      guard++;
    end
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic drive_frame(input logic [7:0] b, input bit bad_stop, input int gbit);
    for (int k = 0; k < 10; k++) begin
      rx_bit = (k == 0) ? 1'b0 : (k == 9) ? !bad_stop : b[k-1];
      if (k == gbit) begin
        rxd = rx_bit;
        repeat (BIT_CLKS/2 + 2) @(negedge clk);
        rxd = !rx_bit;
        repeat (TICK_DIV) @(negedge clk);
        rxd = rx_bit;
        repeat (BIT_CLKS/2 - 2 - TICK_DIV) @(negedge clk);
      end else begin
        rxd = rx_bit;
        repeat (BIT_CLKS) @(negedge clk);
      end
    end
    rxd = 1'b1;
  endtask

  task automatic rx_flush();
    logic [7:0] d;
    repeat (BIT_CLKS * 12) @(negedge clk);
    bus_read(2'd2, d);
  endtask

  // monitor: decodes txd and compares against the scoreboard
  initial begin : tx_monitor
    forever begin
      @(negedge clk);
      if (rst_n && mon_prev && !txd && !brk_on) begin
        repeat (BIT_CLKS/2 - 1) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
          repeat (BIT_CLKS) @(negedge clk);
          mon_got[k] = txd;
        end
        repeat (BIT_CLKS) @(negedge clk);
        mon_stop = txd;
        frames_seen++;
        check8("R3 stop bit", {7'd0, mon_stop}, 8'h01);
        if (exp_q.size() == 0) begin
          check8("R3 unexpected frame", mon_got, 8'hxx);
        end else begin
          mon_exp = exp_q.pop_front();
          check8("R3 frame data", mon_got, mon_exp);
        end
      end
      mon_prev = txd;
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    bus_read(2'd0, rd_val); check8("R1 ctrl", rd_val, 8'h00);
    bus_read(2'd1, rd_val); check8("R1 status", rd_val, 8'hC0);
    check8("R1 txd", {7'd0, txd}, 8'h01);
    check8("R1 irq", {7'd0, irq}, 8'h00);

    // R2 control readback; R13 transmit-done source
    bus_write(2'd0, 8'h5A);
    bus_read(2'd0, rd_val); check8("R2 ctrl readback", rd_val, 8'h5A);
    check8("R13 irq tx done", {7'd0, irq}, 8'h01);
    bus_write(2'd0, 8'h00);
    check8("R13 irq masked", {7'd0, irq}, 8'h00);

    // R5 transmitter off holds the byte; R13 transmit-empty source
    bus_write(2'd0, 8'h80);
    check8("R13 irq tx empty", {7'd0, irq}, 8'h01);
    exp_q.push_back(8'h3C);
    bus_write(2'd2, 8'h3C);
    bus_read(2'd1, rd_val); check8("R4 R5 pending status", rd_val, 8'h00);
    check8("R13 irq after fill", {7'd0, irq}, 8'h00);
    repeat (BIT_CLKS * 3) @(negedge clk);
    check8("R5 no frame while off", 8'(frames_seen), 8'h00);
    check8("R5 line idle", {7'd0, txd}, 8'h01);
    bus_write(2'd0, 8'h88);
    repeat (8) @(negedge clk);
    bus_read(2'd1, rd_val); check8("R4 shifting status", rd_val, 8'h80);
    wait_tx_idle();
    check8("R4 done status", 8'(frames_seen), 8'h01);

    // R3 back-to-back characters
    bus_write(2'd0, 8'h08);
    send_tx(8'h55);
    send_tx(8'hA1);
    send_tx(8'hFF);
    send_tx(8'h00);
    wait_tx_idle();

    // R5 disable during a character
    send_tx(8'h96);
    repeat (10) @(negedge clk);
    bus_write(2'd2, 8'h69);
    bus_write(2'd0, 8'h00);
    seen0 = frames_seen;
    repeat (BIT_CLKS * 25) @(negedge clk);
    check8("R5 only current frame", 8'(frames_seen - seen0), 8'h01);
    bus_read(2'd1, rd_val); check8("R5 byte held", rd_val, 8'h00);
    exp_q.push_back(8'h69);
    bus_write(2'd0, 8'h08);
    wait_tx_idle();

    // R6 line break
    brk_on = 1'b1;
    bus_write(2'd0, 8'h01);
    repeat (5) @(negedge clk);
    check8("R6 break low", {7'd0, txd}, 8'h00);
    bus_write(2'd0, 8'h00);
    repeat (3) @(negedge clk);
    check8("R6 break released", {7'd0, txd}, 8'h01);
    brk_on = 1'b0;

    // R7 receive, R11 idle
    bus_write(2'd0, 8'h04);
    drive_frame(8'hC3, 1'b0, -1);
    bus_read(2'd1, rd_val); check8("R7 full status", rd_val, 8'hE0);
    check8("R13 irq rx disabled", {7'd0, irq}, 8'h00);
    bus_write(2'd0, 8'h24);
    check8("R13 irq rx full", {7'd0, irq}, 8'h01);
    bus_read(2'd2, rd_val); check8("R7 data", rd_val, 8'hC3);
    bus_read(2'd1, rd_val); check8("R7 cleared", rd_val, 8'hC0);
    check8("R13 irq rx cleared", {7'd0, irq}, 8'h00);
    repeat (300) @(negedge clk);
    bus_read(2'd1, rd_val); check8("R11 idle not yet", rd_val, 8'hC0);
    repeat (400) @(negedge clk);
    bus_read(2'd1, rd_val); check8("R11 idle set", rd_val, 8'hD0);
    bus_write(2'd0, 8'h14);
    check8("R13 irq idle", {7'd0, irq}, 8'h01);
    bus_read(2'd2, rd_val);
    bus_read(2'd1, rd_val); check8("R11 idle cleared", rd_val, 8'hC0);
    repeat (BIT_CLKS * 12) @(negedge clk);
    bus_read(2'd1, rd_val); check8("R11 once per char", rd_val, 8'hC0);

    // R8 overrun
    bus_write(2'd0, 8'h04);
    drive_frame(8'h11, 1'b0, -1);
    drive_frame(8'h22, 1'b0, -1);
    bus_read(2'd1, rd_val); check8("R8 overrun status", rd_val, 8'hE8);
    bus_read(2'd2, rd_val); check8("R8 first byte kept", rd_val, 8'h11);
    bus_read(2'd1, rd_val); check8("R8 cleared", rd_val, 8'hC0);
    rx_flush();

    // R9 framing
    drive_frame(8'h7E, 1'b1, -1);
    repeat (BIT_CLKS) @(negedge clk);
    bus_read(2'd1, rd_val); check8("R9 framing status", rd_val, 8'hE2);
    bus_read(2'd2, rd_val); check8("R9 data", rd_val, 8'h7E);
    rx_flush();

    // R10 noise
    drive_frame(8'h5A, 1'b0, 3);
    bus_read(2'd1, rd_val); check8("R10 noise status", rd_val, 8'hE4);
    bus_read(2'd2, rd_val); check8("R10 majority data", rd_val, 8'h5A);
    rx_flush();

    // R12 abort mid-character
    fork
      drive_frame(8'hF0, 1'b0, -1);
      begin
        repeat (BIT_CLKS * 3) @(negedge clk);
        bus_write(2'd0, 8'h00);
      end
    join
    repeat (20) @(negedge clk);
    bus_write(2'd0, 8'h04);
    repeat (BIT_CLKS * 2) @(negedge clk);
    bus_read(2'd1, rd_val); check8("R12 aborted", rd_val, 8'hC0);

    // R12 receiver off ignores the line
    bus_write(2'd0, 8'h00);
    drive_frame(8'h33, 1'b0, -1);
    bus_read(2'd1, rd_val); check8("R12 ignored", rd_val, 8'hC0);
    bus_write(2'd0, 8'h04);
    drive_frame(8'h81, 1'b0, -1);
    bus_read(2'd1, rd_val); check8("R12 re-enabled", rd_val, 8'hE0);
    bus_read(2'd2, rd_val); check8("R7 data after re-enable", rd_val, 8'h81);

    check8("R3 scoreboard drained", 8'(exp_q.size()), 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule